// File: doc/BRIEF.md
# Delta-Coded Varint Identifier Decoder

This block turns a compressed posting stream into a sequence of sorted 32-bit document identifiers. The stream is a series of variable-length integers. Every byte holds seven payload bits plus a flag in its top bit that says whether the integer goes on into the next byte. Each decoded integer is the gap from the previous identifier. The block keeps a running total and emits that total as the next identifier each time an integer completes.

Bytes enter one per cycle over a valid/ready handshake. Results leave through a single-entry valid/ready output register. Identifiers wrap modulo 2^32. A pulse on `list_start` begins a new list. It zeroes the running total and drops any partly gathered integer. An integer that still signals continuation at the largest legal byte count is malformed. Such an integer is discarded, and a sticky error flag is raised.

Top module: `vbyte_delta_decoder`

## Requirements
- R1: Bit 7 of each input byte is the continuation flag (1 = more bytes follow, 0 = final byte) and bits 6..0 are payload; the first byte of an integer supplies value bits 6..0, the second bits 13..7, and so on.
- R2: An integer spans at most five bytes; payload bits of the fifth byte that land above bit 31 are dropped, so bytes EE 9D F5 ED 03 (hex) decode to 0x3DBD4EEE and FF FF FF FF 7F decode to 0xFFFFFFFF.
- R3: Each emitted identifier equals the previous identifier plus the decoded gap, modulo 2^32; the gaps 34, 52, 161, 54, 373, 40 of a fresh list yield 34, 86, 247, 301, 674, 714.
- R4: A `list_start` pulse zeroes the running identifier and discards any partial integer; if a byte is accepted in the same cycle, that byte is decoded as the first byte of the new list.
- R5: A fifth byte with bit 7 set raises `fmt_err`, produces no output, leaves the running identifier unchanged and discards the partial integer, so the next byte starts a new integer.
- R6: `fmt_err` stays high until reset, including across `list_start`.
- R7: `out_last` equals the `in_last` tag of the byte that completed the integer.
- R8: While `out_valid` is high and `out_ready` low, `out_id` and `out_last` hold their values and no input byte is accepted; no byte is lost or repeated.
- R9: Reset clears the running identifier, the partial integer, the byte position and `fmt_err`, and leaves `out_valid` low and `in_ready` high.
- R10: With `out_ready` held high the block accepts one byte every cycle, and an identifier appears on the cycle after its final byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| list_start | input | 1 | Begins a new list; clears running identifier and partial integer |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take an input byte |
| in_byte | input | 8 | Continuation flag in bit 7, payload in bits 6..0 |
| in_last | input | 1 | Tag marking the byte that ends the list |
| out_valid | output | 1 | Identifier present |
| out_ready | input | 1 | Consumer takes the identifier |
| out_id | output | ID_W | Reconstructed identifier |
| out_last | output | 1 | Identifier closes its list |
| fmt_err | output | 1 | Sticky flag for an over-long integer |

## Verification
The embedded properties check, cycle by cycle, the following: a held output stays unchanged under back-pressure, a final byte always yields an output on the next cycle, the error flag never drops, the byte position stays within five, and a list-start clears the partial state. Whether the numeric values are right can only be shown by the bench's scenarios. These scenarios cover group placement, fifth-byte truncation, running sums across wrap-around, mid-integer list restarts and the recovery after a malformed integer. The bench compares against a model that encodes gaps and sums them arithmetically, under steady, random and long-stalled output readiness.

// File: rtl/vbyte_delta_decoder.sv
module vbyte_delta_decoder #(
  parameter int ID_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            list_start,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_byte,
  input  logic            in_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [ID_W-1:0] out_id,
  output logic            out_last,
  output logic            fmt_err
);
  localparam int GRP       = 7;
  localparam int MAX_BYTES = (ID_W + GRP - 1) / GRP;
  localparam int POS_W     = $clog2(MAX_BYTES);
  localparam int ACC_W     = GRP * MAX_BYTES;

  logic [ACC_W-1:0] acc;
  logic [POS_W-1:0] pos;
  logic [ID_W-1:0]  running;

  logic             take, more, at_limit;
  logic [ACC_W-1:0] base_acc, placed, merged;
  logic [POS_W-1:0] base_pos;
  logic [ID_W-1:0]  base_run, sum;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign more     = in_byte[7];

  assign base_acc = list_start ? '0 : acc;
  assign base_pos = list_start ? '0 : pos;
  assign base_run = list_start ? '0 : running;
  assign at_limit = (base_pos == POS_W'(MAX_BYTES - 1));
  assign placed   = ACC_W'(in_byte[6:0]) << (GRP * int'(base_pos));
  assign merged   = base_acc | placed;
  assign sum      = base_run + merged[ID_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      pos       <= '0;
      running   <= '0;
      out_valid <= 1'b0;
      out_id    <= '0;
      out_last  <= 1'b0;
      fmt_err   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (list_start) begin
        acc     <= '0;
        pos     <= '0;
        running <= '0;
      end
      if (take) begin
        if (!more) begin
          out_id    <= sum;
          out_last  <= in_last;
          out_valid <= 1'b1;
          running   <= sum;
          acc       <= '0;
          pos       <= '0;
        end else if (at_limit) begin
          fmt_err <= 1'b1;
          acc     <= '0;
          pos     <= '0;
        end else begin
          acc <= merged;
          pos <= base_pos + POS_W'(1);
        end
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_id) && $stable(out_last));

  assert_emit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_byte[7] |=> out_valid);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);

  assert_pos_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_W'(MAX_BYTES - 1));

  assert_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_byte[7] && !list_start && pos == POS_W'(MAX_BYTES - 1)
    |=> fmt_err && pos == '0 && acc == '0);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    list_start && !(in_valid && in_ready) |=> pos == '0 && acc == '0 && running == '0);
endmodule

// File: tb/vbyte_delta_decoder_test.sv
module vbyte_delta_decoder_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        list_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_id;
  logic        out_last;
  logic        fmt_err;

  vbyte_delta_decoder #(.ID_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .list_start(list_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
    .out_last(out_last), .fmt_err(fmt_err)
  );

  always #(PERIOD/2) clk = ~clk;

  int          checks = 0;
  int          fails = 0;
  int          stalls = 0;
  int          rdy_mode = 0;
  int          phase = 0;
  logic [15:0] rlfsr = 16'hACE1;
  logic [31:0] running = 0;
  logic [32:0] exp_q[$];
  logic        held = 0;
  logic [31:0] held_id = 0;
  logic        held_last = 0;
  bit          finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  // output side: drive readiness, compare handshakes against model
  always @(negedge clk) begin
    rlfsr = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
    phase = (phase + 1) % 16;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = rlfsr[0] | rlfsr[5];
      default: out_ready = (phase >= 12);
    endcase
    #2;
    if (rst_n) begin
      if (held)
        check(out_valid && out_id == held_id && out_last == held_last, "R8 hold",
              {31'b0, out_last, out_id}, {31'b0, held_last, held_id});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R3 unexpected output", {32'b0, out_id}, 64'h0);
        else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          check({out_last, out_id} == e, "R3/R7 identifier", {31'b0, out_last, out_id}, {31'b0, e});
        end
      end
      held      = out_valid && !out_ready;
      held_id   = out_id;
      held_last = out_last;
    end else held = 0;
  end

  task automatic put_byte(input logic [7:0] b, input bit last, input bit st);
    @(negedge clk);
    in_valid = 1; in_byte = b; in_last = last; list_start = st;
    #2;
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
      #2;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; list_start = 0; in_last = 0;
  endtask

  task automatic send_int(input logic [31:0] v, input bit last, input bit st);
    logic [31:0] r;
    bit first;
    if (st) running = 0;
    running = running + v;
    exp_q.push_back({last, running});
    r = v;
    first = 1;
    forever begin
      logic [6:0] g;
      bit m;
      g = r[6:0];
      r = r >> 7;
      m = (r != 0);
      put_byte({m, g}, m ? 1'b0 : last, st && first);
      first = 0;
      if (!m) break;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    in_valid = 0; list_start = 1;
    @(negedge clk);
    list_start = 0;
    running = 0;
  endtask

  task automatic drain();
    int n;
    idle();
    n = 0;
    while ((exp_q.size() != 0 || out_valid) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) check(0, "R8 drain", exp_q.size(), 0);
    @(negedge clk);
  endtask

  logic [31:0] bounds[12] = '{32'd0, 32'd1, 32'd127, 32'd128, 32'd16383, 32'd16384,
                             32'h001FFFFF, 32'h00200000, 32'h0FFFFFFF, 32'h10000000,
                             32'hFFFFFFFF, 32'h7FFFFFFF};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    // R9 reset state
    check(out_valid == 0, "R9 out_valid", out_valid, 0);
    check(in_ready == 1, "R9 in_ready", in_ready, 1);
    check(fmt_err == 0, "R9 fmt_err", fmt_err, 0);

    // R3 gap example
    send_int(34, 0, 1); send_int(52, 0, 0); send_int(161, 0, 0);
    send_int(54, 0, 0); send_int(373, 0, 0); send_int(40, 1, 0);
    drain();
    check(running == 714, "R3 model sum", running, 714);

    // R2 five-byte examples, raw bytes
    running = 32'h3DBD4EEE; exp_q.push_back({1'b0, 32'h3DBD4EEE});
    put_byte(8'hEE, 0, 1); put_byte(8'h9D, 0, 0); put_byte(8'hF5, 0, 0);
    put_byte(8'hED, 0, 0); put_byte(8'h03, 0, 0);
    running = 32'hFFFFFFFF; exp_q.push_back({1'b1, 32'hFFFFFFFF});
    put_byte(8'hFF, 0, 1); put_byte(8'hFF, 0, 0); put_byte(8'hFF, 0, 0);
    put_byte(8'hFF, 0, 0); put_byte(8'h7F, 1, 0);
    drain();

    // R1 boundary group widths, wrap-around of R3, steady then random readiness
    for (int m = 0; m < 2; m++) begin
      rdy_mode = m;
      pulse_start();
      for (int i = 0; i < 12; i++) send_int(bounds[i], i == 11, 0);
      drain();
    end

    // R1 sweep of all small gaps
    rdy_mode = 1;
    pulse_start();
    for (int v = 0; v < 1024; v++) send_int(v, v == 1023, 0);
    drain();

    // R1 pseudo-random gaps of every length
    begin
      logic [31:0] x;
      x = 32'h1234_5677;
      for (int i = 0; i < 1500; i++) begin
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        send_int(x >> (x[4:0]), i % 97 == 96, i % 211 == 0);
      end
    end
    drain();

    // R10 one byte per cycle with steady readiness
    rdy_mode = 0;
    drain();
    stalls = 0;
    pulse_start();
    for (int i = 0; i < 20; i++) send_int(i + 1, 0, 0);
    check(stalls == 0, "R10 throughput", stalls, 0);
    put_byte(8'h05, 0, 0);
    exp_q.push_back({1'b0, running + 32'd5}); running = running + 5;
    @(negedge clk); in_valid = 0; #2;
    check(out_valid && out_id == running, "R10 latency", {31'b0, out_valid, out_id}, {32'b1, running});
    drain();

    // R4 list_start mid-integer discards partial
    put_byte(8'h85, 0, 0);
    pulse_start();
    send_int(3, 0, 0);
    drain();
    // R4 coincident list_start with an accepted byte
    send_int(100, 0, 0);
    send_int(9, 1, 1);
    drain();

    // R5 over-long integer
    check(fmt_err == 0, "R5 flag before", fmt_err, 0);
    send_int(50, 0, 1);
    for (int i = 0; i < 5; i++) put_byte(8'h80, 0, 0);
    send_int(7, 0, 0);
    drain();
    check(fmt_err == 1, "R5 flag set", fmt_err, 1);
    // R6 sticky across list_start
    pulse_start();
    send_int(2, 1, 0);
    drain();
    check(fmt_err == 1, "R6 sticky", fmt_err, 1);

    // R8 long back-pressure windows, R7 last tags
    rdy_mode = 2;
    pulse_start();
    for (int i = 0; i < 60; i++) send_int((i * 37) << (i % 20), i % 3 == 0, 0);
    drain();
    rdy_mode = 0;

    // R9 reset clears running identifier and error
    send_int(10, 0, 0);
    drain();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; #2;
    check(fmt_err == 0, "R9 flag cleared", fmt_err, 0);
    running = 0;
    send_int(3, 0, 0);
    drain();

    finish_run();
  end
endmodule